// File: doc/BRIEF.md
# Digit Sequence Combination Lock

This block watches a stream of decimal digits, one per clock cycle, and raises its `unlock` output once the digits 3, 8 and 4 have arrived in that order. Each digit is a 4-bit binary value. It counts only in a cycle where the qualifier `digit_valid` is high. The machine has four states held in two flip-flops. The output is Mealy-style: it is a combinational function of the current state and the digit now presented. As a result, `unlock` goes high in the same cycle as the final 4, before any clock edge has captured it.

A partial match that is broken by a 3 does not fall all the way back to the beginning. It resumes as if that 3 were the first digit of the code. Once the code has been matched, the machine stays open whatever arrives afterwards, until a synchronous active-low reset returns it to the locked start state.

Top module: `digit_lock`

## Requirements
- R1: After a clock edge with `rst_n` low, the machine is in the start state (encoding 2'b00) and `unlock` is 0 for any digit presented. A following valid 8 then 4 does not unlock.
- R2: The valid digits 3, 8, 4 in consecutive accepted cycles drive `unlock` to 1 combinationally while the 4 is presented, before the clock edge that captures it. `unlock` is 0 while the 3 and the 8 are presented.
- R3: In the start state any valid digit other than 3 keeps the machine there. In the "seen 3" state (2'b01) a valid 3 keeps it there, so 3-3-8-4 unlocks.
- R4: In the "seen 3,8" state (2'b10) a valid 3 moves the machine to "seen 3" with output 0, so 3-8-3-8-4 unlocks.
- R5: A valid digit other than 8 or 3 in "seen 3", or other than 4 or 3 in "seen 3,8", returns the machine to start with output 0. For example, 3-8-5-4 does not unlock.
- R6: Input codes 10 to 15 are treated as non-matching digits. In any locked state they lead to start.
- R7: Once unlocked (state 2'b11), `unlock` stays 1 for every input, valid or not, until reset.
- R8: When `digit_valid` is low the state does not change. `unlock` is then 1 only if the machine is already in the unlocked state, even if a 4 is presented in "seen 3,8".
- R9: Reset takes priority over a valid digit in the same cycle, including in the unlocked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| digit_valid | input | 1 | High when `digit` holds a digit to accept this cycle |
| digit | input | 4 | Binary-coded digit |
| unlock | output | 1 | Mealy unlock indication |

## Verification
The hardest situations to reach from the ports are the overlapping recoveries. These are a 3 that breaks a partial match and must restart the match at "seen 3", and idle cycles with `digit_valid` low placed in the middle of a partial match. Random stimulus picks the digits 3, 8 and 4 far more often than other values and lowers `digit_valid` about a quarter of the time, so these paths come up often. Directed sequences add 3-3-8-4, 3-8-3-8-4, the near miss 3-8-5-4, out-of-range codes, and a reset that lands on a valid digit while the machine is unlocked.

// File: rtl/digit_lock_pkg.sv
// Shared definitions for the digit lock: the digit width, the fixed code digits
// and the state encoding. Assumes decimal digits in plain binary.
package digit_lock_pkg;
    localparam int DIGIT_W = 4;
    localparam int STATE_W = 2;

    localparam logic [DIGIT_W-1:0] KEY_D0 = DIGIT_W'(3);
    localparam logic [DIGIT_W-1:0] KEY_D1 = DIGIT_W'(8);
    localparam logic [DIGIT_W-1:0] KEY_D2 = DIGIT_W'(4);

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 2'b00,
        ST_GOT_A  = 2'b01,
        ST_GOT_AB = 2'b10,
        ST_OPEN   = 2'b11
    } lock_state_t;
endpackage

// File: rtl/digit_lock_next.sv
// Next-state function of the lock. A qualified digit advances, restarts or
// clears the partial match. An unqualified cycle holds the state. Assumes the
// open state is absorbing and that reset is applied by the state register.
module digit_lock_next
    import digit_lock_pkg::*;
(
    input  lock_state_t        cur_state,
    input  logic               take,
    input  logic [DIGIT_W-1:0] digit,
    output lock_state_t        nxt_state
);
    logic is_first;
    logic is_second;
    logic is_third;

    // Compare the incoming digit against each code digit.
    always_comb begin
        is_first  = (digit == KEY_D0);
        is_second = (digit == KEY_D1);
        is_third  = (digit == KEY_D2);
    end

    // Choose the successor state from the current state and the qualified digit.
    always_comb begin
        nxt_state = cur_state;
        if (take) begin
            unique case (cur_state)
                ST_IDLE:   nxt_state = is_first ? ST_GOT_A : ST_IDLE;
                ST_GOT_A:  nxt_state = is_second ? ST_GOT_AB :
                                       (is_first ? ST_GOT_A : ST_IDLE);
                ST_GOT_AB: nxt_state = is_third ? ST_OPEN :
                                       (is_first ? ST_GOT_A : ST_IDLE);
                ST_OPEN:   nxt_state = ST_OPEN;
                default:   nxt_state = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/digit_lock_state.sv
// Two-flop state register with synchronous active-low reset. Assumes the
// clock is used only as the edge of this register.
module digit_lock_state
    import digit_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  lock_state_t nxt_state,
    output lock_state_t cur_state
);
    // Capture the successor state, or start on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_state <= ST_IDLE;
        else        cur_state <= nxt_state;
    end

    // Reset wins over any digit and leaves the machine at start.
    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> cur_state == ST_IDLE);

    // An unqualified cycle leaves the state unchanged.
    assert_hold_idle_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(take)) |-> $stable(cur_state));

    // The open state is never left except by reset.
    assert_open_absorbing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cur_state) == ST_OPEN) |-> cur_state == ST_OPEN);
endmodule

// File: rtl/digit_lock_out.sv
// Mealy unlock decode: high in the open state, or while the final code digit is
// presented with its qualifier in the state that has seen the first two digits.
// Assumes the output is used unregistered.
module digit_lock_out
    import digit_lock_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  lock_state_t        cur_state,
    input  logic               take,
    input  logic [DIGIT_W-1:0] digit,
    output logic               unlock
);
    // Combine the terminal-state term with the completing-transition term.
    always_comb begin
        unlock = (cur_state == ST_OPEN) ||
                 (take && cur_state == ST_GOT_AB && digit == KEY_D2);
    end

    // Every input keeps the output high once open.
    assert_open_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == ST_OPEN |-> unlock);

    // With no qualifier the completing digit cannot unlock.
    assert_no_unqualified_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && cur_state != ST_OPEN) |-> !unlock);
endmodule

// File: rtl/digit_lock.sv
// Top of the digit sequence lock: ties the next-state logic, the state register
// and the Mealy output decode together. Assumes one digit per accepted cycle.
module digit_lock
    import digit_lock_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               digit_valid,
    input  logic [DIGIT_W-1:0] digit,
    output logic               unlock
);
    lock_state_t cur_state;
    lock_state_t nxt_state;

    digit_lock_next u_next (
        .cur_state (cur_state),
        .take      (digit_valid),
        .digit     (digit),
        .nxt_state (nxt_state)
    );

    digit_lock_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (digit_valid),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    digit_lock_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_state (cur_state),
        .take      (digit_valid),
        .digit     (digit),
        .unlock    (unlock)
    );

    // Out-of-range codes never advance a locked machine.
    assert_bad_code_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_valid && digit > DIGIT_W'(9) && cur_state != ST_OPEN) |=> cur_state == ST_IDLE);

    // A qualified 3 from any locked state lands in the first-digit state.
    assert_restart_on_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_valid && digit == KEY_D0 && cur_state != ST_OPEN) |=> cur_state == ST_GOT_A);
endmodule

// File: tb/digit_lock_test.sv
// Self-checking bench for digit_lock: directed sequences plus seeded random
// digits, compared against a behavioural model kept in the bench.
module digit_lock_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       digit_valid = 1'b0;
    logic [3:0] digit = 4'd0;
    logic       unlock;

    int checks = 0;
    int errors = 0;
    int mstate = 0;   // bench model: 0 start, 1 seen 3, 2 seen 3-8, 3 open
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    digit_lock uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .digit_valid (digit_valid),
        .digit       (digit),
        .unlock      (unlock)
    );

    function automatic int model_next(int s, bit r, bit v, int d);
        if (!r) return 0;
        if (!v) return s;
        case (s)
            0: return (d == 3) ? 1 : 0;
            1: return (d == 8) ? 2 : ((d == 3) ? 1 : 0);
            2: return (d == 4) ? 3 : ((d == 3) ? 1 : 0);
            default: return 3;
        endcase
    endfunction

    function automatic bit model_out(int s, bit v, int d);
        return (s == 3) || (v && s == 2 && d == 4);
    endfunction

    // One cycle: drive at the falling edge, check the Mealy output, then clock.
    task automatic step(bit r, bit v, int d, string tag);
        bit exp;
        @(negedge clk);
        rst_n = r;
        digit_valid = v;
        digit = 4'(d);
        #1;
        exp = model_out(mstate, v, d);
        checks++;
        if (unlock !== exp) begin
            errors++;
            $display("FAIL %s: unlock=%b expected=%b (digit=%0d valid=%b)", tag, unlock, exp, d, v);
        end
        @(posedge clk);
        mstate = model_next(mstate, r, v, d);
    endtask

    task automatic feed(int d, string tag);
        step(1'b1, 1'b1, d, tag);
    endtask

    task automatic do_reset();
        step(1'b0, 1'b1, 3, "R9");
        step(1'b0, 1'b0, 0, "R1");
    endtask

    initial begin
        int r;
        int d;
        r = $urandom(1234);
        do_reset();
        // R1: no unlock after reset, and 8-4 alone does nothing
        step(1'b1, 1'b1, 4, "R1");
        feed(8, "R1"); feed(4, "R1");
        // R2: plain code, output high during the 4
        do_reset();
        feed(3, "R2"); feed(8, "R2"); feed(4, "R2");
        // R7: stays open
        feed(5, "R7"); step(1'b1, 1'b0, 0, "R7"); feed(15, "R7"); feed(3, "R7");
        // R3: repeated 3 and non-3 in start
        do_reset();
        feed(9, "R3"); feed(3, "R3"); feed(3, "R3"); feed(8, "R3"); feed(4, "R3");
        // R4: 3-8-3-8-4
        do_reset();
        feed(3, "R4"); feed(8, "R4"); feed(3, "R4"); feed(8, "R4"); feed(4, "R4");
        // R5: near miss 3-8-5-4, and 3-7-8-4
        do_reset();
        feed(3, "R5"); feed(8, "R5"); feed(5, "R5"); feed(4, "R5");
        feed(3, "R5"); feed(7, "R5"); feed(8, "R5"); feed(4, "R5");
        // R6: out-of-range codes
        feed(3, "R6"); feed(8, "R6"); feed(12, "R6"); feed(4, "R6");
        feed(3, "R6"); feed(11, "R6"); feed(8, "R6"); feed(4, "R6");
        // R8: idle cycles mid-sequence, unqualified 4 does not open
        feed(3, "R8"); step(1'b1, 1'b0, 9, "R8"); feed(8, "R8");
        step(1'b1, 1'b0, 4, "R8"); step(1'b1, 1'b0, 1, "R8"); feed(4, "R8");
        // R9: reset with a valid digit while open, then 8-4 must not open
        step(1'b0, 1'b1, 4, "R9");
        feed(8, "R9"); feed(4, "R9");
        feed(3, "R9"); feed(8, "R9"); feed(4, "R9");
        // Random mix biased to code digits
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            r = $urandom_range(0, 99);
            if (r < 25) d = 3; else if (r < 45) d = 8; else if (r < 65) d = 4;
            else d = $urandom_range(0, 15);
            step(($urandom_range(0, 99) >= 2), ($urandom_range(0, 3) != 0), d, "R2/random");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule